// File: doc/BRIEF.md
# Write-once register lock controller

This block keeps the safety-relevant configuration fields of a timer: the dead-time code, the break controls, the off-state selectors, the per-channel idle levels and polarities, and the per-channel compare mode and preload bits. It sits behind a simple write port that carries an address, a data word and a two-lane byte strobe. For every field touched by a write, the block decides whether the write may change that field. It bases the decision on a 2-bit protection level and on whether each channel is currently configured as an output.

The protection level can be written once after reset. The first write that strobes the low byte of the break/dead-time word sets the level, and that write uses up the single chance even when it writes zero. Each step of the level freezes more fields. A write that targets a frozen field and tries to change it is dropped without any other effect, and a one-cycle rejection pulse marks it. Fields in the same write that are still open take the new value.

Top module: `lockctl_top`

## Requirements
- R1: After reset every held field, the protection level and the rejection pulse are zero.
- R2: At protection level 0 every field is writable. Strobe bit 0 enables data bits 7:0 and strobe bit 1 enables data bits 15:8. Word 0 holds level [1:0], break enable [2], break polarity [3], auto output enable [4], run off-state [5], idle off-state [6] and dead-time code [15:8]. Word 1 holds idle level of channel i at bit i and polarity of channel i at bit 8+i. Word 2 holds, for channel i, mode at bits 4i+2:4i and preload at bit 4i+3.
- R3: The first write that strobes byte 0 of word 0 sets the level and consumes the only lock write, even when it writes 0. Later attempts leave the level unchanged.
- R4: At level 1 or above, the dead-time code, the three break control bits and the idle levels cannot change.
- R5: At level 2 or above, the two off-state bits and the polarity of every output channel also cannot change.
- R6: At level 3, the mode and preload bits of every output channel also cannot change.
- R7: Polarity, mode and preload of a channel that is not an output stay writable at every level.
- R8: A write that carries a new level together with other fields is judged against the level held before that write.
- R9: A write in which a frozen, strobed field would change raises the rejection output for exactly the next cycle. Open fields of the same write still update. A write that leaves every frozen field at its held value raises no rejection.
- R10: An accepted write is visible on the field outputs one cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request valid |
| wr_addr | input | ADDR_W | Word select (0 break/dead-time, 1 output control, 2 compare control) |
| wr_data | input | 16 | Write data |
| wr_strb | input | 2 | Byte lane enables |
| ch_is_out | input | NCH | Channel configured as output |
| dt_code | output | 8 | Held dead-time code |
| lock_lvl | output | 2 | Current protection level |
| brk_en | output | 1 | Break enable |
| brk_pol | output | 1 | Break polarity |
| auto_oe | output | 1 | Automatic output enable |
| off_run | output | 1 | Off-state select in run mode |
| off_idle | output | 1 | Off-state select in idle mode |
| idle_lvl | output | NCH | Per-channel idle level |
| ch_pol | output | NCH | Per-channel polarity |
| oc_mode | output | NCH*MODE_W | Per-channel compare mode, channel 0 lowest |
| oc_pre | output | NCH | Per-channel preload enable |
| wr_reject | output | 1 | One-cycle pulse after a rejected write |

## Verification
Every result is one register deep: field updates, the new level and the rejection pulse all appear in the cycle after the edge that samples the write. The bench drives each write at a falling edge and holds it across one rising edge. It reads all outputs at the next falling edge, and in the rejection cases it reads the pulse again one cycle later to confirm that it has cleared. Each lock scenario starts from a fresh reset because the level can be written only once.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;

   localparam int DATA_W = 16;
   localparam int LANES  = DATA_W / 8;
   localparam int SLOT_W = 4;

   typedef enum logic [1:0] {
      LVL_OPEN = 2'd0,
      LVL_ONE  = 2'd1,
      LVL_TWO  = 2'd2,
      LVL_FULL = 2'd3
   } lock_lvl_e;

endpackage

// File: rtl/lockctl_gfield.sv
module lockctl_gfield #(
   parameter int          W        = 1,
   parameter bit          REJ_SAME = 1'b0,
   parameter logic [W-1:0] RST     = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  logic         allow,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         blocked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= RST;
      else if (hit && allow) q <= d;
   end

   generate
      if (REJ_SAME) begin : g_any
         assign blocked = hit && !allow;
      end else begin : g_chg
         assign blocked = hit && !allow && (d != q);
      end
   endgenerate

endmodule

// File: rtl/lockctl_level.sv
module lockctl_level
   import lockctl_pkg::*;
#(
   parameter bit REJ_SAME = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic [1:0] d,
   output logic [1:0] lvl,
   output logic       used,
   output logic       blocked
);

   lock_lvl_e lvl_q;
   logic      used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= LVL_OPEN;
         used_q <= 1'b0;
      end else if (hit && !used_q) begin
         lvl_q  <= lock_lvl_e'(d);
         used_q <= 1'b1;
      end
   end

   generate
      if (REJ_SAME) begin : g_any
         assign blocked = hit && used_q;
      end else begin : g_chg
         assign blocked = hit && used_q && (d != lvl_q);
      end
   endgenerate

   assign lvl  = lvl_q;
   assign used = used_q;

endmodule

// File: rtl/lockctl_top.sv
module lockctl_top
   import lockctl_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int MODE_W   = 3,
   parameter int ADDR_W   = 2,
   parameter bit REJ_SAME = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [15:0]             wr_data,
   input  logic [1:0]              wr_strb,
   input  logic [NCH-1:0]          ch_is_out,
   output logic [7:0]              dt_code,
   output logic [1:0]              lock_lvl,
   output logic                    brk_en,
   output logic                    brk_pol,
   output logic                    auto_oe,
   output logic                    off_run,
   output logic                    off_idle,
   output logic [NCH-1:0]          idle_lvl,
   output logic [NCH-1:0]          ch_pol,
   output logic [NCH*MODE_W-1:0]   oc_mode,
   output logic [NCH-1:0]          oc_pre,
   output logic                    wr_reject
);

   localparam logic [ADDR_W-1:0] A_BDT = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(2);
   localparam int CH_PER_LANE = 8 / SLOT_W;
   localparam int NBLK        = 5 + 2 * NCH;

   // elaboration-time parameter checks
   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("lockctl_top: NCH must be 1..4");
      end
      if (MODE_W < 1 || MODE_W > SLOT_W - 1) begin : g_bad_mode
         $error("lockctl_top: MODE_W must be 1..3");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("lockctl_top: ADDR_W must be at least 2");
      end
   endgenerate

   // word and lane decode
   logic sel_bdt, sel_out, sel_cmp;
   logic [LANES-1:0] hit_bdt, hit_out, hit_cmp;

   assign sel_bdt = wr_en && (wr_addr == A_BDT);
   assign sel_out = wr_en && (wr_addr == A_OUT);
   assign sel_cmp = wr_en && (wr_addr == A_CMP);
   assign hit_bdt = {LANES{sel_bdt}} & wr_strb;
   assign hit_out = {LANES{sel_out}} & wr_strb;
   assign hit_cmp = {LANES{sel_cmp}} & wr_strb;

   // protection level and derived permissions (old level)
   logic       lock_used;
   logic       open_l1, open_l2, open_l3;
   logic [NBLK-1:0] blk;

   lockctl_level #(.REJ_SAME(REJ_SAME)) level_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_bdt[0]),
      .d       (wr_data[1:0]),
      .lvl     (lock_lvl),
      .used    (lock_used),
      .blocked (blk[0])
   );

   assign open_l1 = (lock_lvl == LVL_OPEN);
   assign open_l2 = (lock_lvl == LVL_OPEN) || (lock_lvl == LVL_ONE);
   assign open_l3 = (lock_lvl != LVL_FULL);

   // break/dead-time word
   logic [2:0] brk_q;
   logic [1:0] off_q;

   lockctl_gfield #(.W(3), .REJ_SAME(REJ_SAME)) brk_i (
      .clk(clk), .rst_n(rst_n), .hit(hit_bdt[0]), .allow(open_l1),
      .d(wr_data[4:2]), .q(brk_q), .blocked(blk[1])
   );

   lockctl_gfield #(.W(2), .REJ_SAME(REJ_SAME)) off_i (
      .clk(clk), .rst_n(rst_n), .hit(hit_bdt[0]), .allow(open_l2),
      .d(wr_data[6:5]), .q(off_q), .blocked(blk[2])
   );

   lockctl_gfield #(.W(8), .REJ_SAME(REJ_SAME)) dt_i (
      .clk(clk), .rst_n(rst_n), .hit(hit_bdt[1]), .allow(open_l1),
      .d(wr_data[15:8]), .q(dt_code), .blocked(blk[3])
   );

   assign brk_en   = brk_q[0];
   assign brk_pol  = brk_q[1];
   assign auto_oe  = brk_q[2];
   assign off_run  = off_q[0];
   assign off_idle = off_q[1];

   // output control word: idle levels
   lockctl_gfield #(.W(NCH), .REJ_SAME(REJ_SAME)) idle_i (
      .clk(clk), .rst_n(rst_n), .hit(hit_out[0]), .allow(open_l1),
      .d(wr_data[NCH-1:0]), .q(idle_lvl), .blocked(blk[4])
   );

   // per-channel polarity and compare control
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         localparam int LO   = SLOT_W * i;
         localparam int LANE = i / CH_PER_LANE;
         logic [MODE_W:0] slot_q;

         lockctl_gfield #(.W(1), .REJ_SAME(REJ_SAME)) pol_i (
            .clk(clk), .rst_n(rst_n), .hit(hit_out[1]),
            .allow(open_l2 || !ch_is_out[i]),
            .d(wr_data[8+i]), .q(ch_pol[i]), .blocked(blk[5+i])
         );

         lockctl_gfield #(.W(MODE_W+1), .REJ_SAME(REJ_SAME)) cmp_i (
            .clk(clk), .rst_n(rst_n), .hit(hit_cmp[LANE]),
            .allow(open_l3 || !ch_is_out[i]),
            .d({wr_data[LO+SLOT_W-1], wr_data[LO+MODE_W-1:LO]}),
            .q(slot_q), .blocked(blk[5+NCH+i])
         );

         assign oc_mode[MODE_W*i +: MODE_W] = slot_q[MODE_W-1:0];
         assign oc_pre[i]                   = slot_q[MODE_W];
      end
   endgenerate

   // rejection pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_reject <= 1'b0;
      else        wr_reject <= |blk;
   end

   logic unused_bits;
   assign unused_bits = ^wr_data;

endmodule

// File: rtl/lockctl_chk.sv
module lockctl_chk #(
   parameter int NCH    = 4,
   parameter int MODE_W = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [NCH-1:0]        ch_is_out,
   input logic [1:0]            lock_lvl,
   input logic                  lock_used,
   input logic [7:0]            dt_code,
   input logic                  brk_en,
   input logic                  brk_pol,
   input logic                  auto_oe,
   input logic                  off_run,
   input logic                  off_idle,
   input logic [NCH-1:0]        idle_lvl,
   input logic [NCH-1:0]        ch_pol,
   input logic [NCH*MODE_W-1:0] oc_mode,
   input logic [NCH-1:0]        oc_pre,
   input logic                  wr_reject
);

   // R3
   lvl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_used |=> $stable(lock_lvl));

   // R4
   dt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_lvl != 2'd0) |=> ($stable(dt_code) && $stable(brk_en) &&
                              $stable(brk_pol) && $stable(auto_oe) &&
                              $stable(idle_lvl)));

   // R5
   off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_lvl[1]) |=> ($stable(off_run) && $stable(off_idle)));

   // R9
   reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $past(wr_en));

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         // R5
         pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_lvl[1] && ch_is_out[i]) |=> $stable(ch_pol[i]));
         // R6
         cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((lock_lvl == 2'd3) && ch_is_out[i]) |=>
               ($stable(oc_mode[MODE_W*i +: MODE_W]) && $stable(oc_pre[i])));
      end
   endgenerate

endmodule

bind lockctl_top lockctl_chk #(.NCH(NCH), .MODE_W(MODE_W)) chk_i (.*);

// File: tb/lockctl_top_tb.sv
`timescale 1ns/1ps
module lockctl_top_tb_top;

   localparam int NCH = 4;
   localparam int MW  = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_addr = '0;
   logic [15:0]     wr_data = '0;
   logic [1:0]      wr_strb = '0;
   logic [NCH-1:0]  ch_is_out = 4'b0101;
   logic [7:0]      dt_code;
   logic [1:0]      lock_lvl;
   logic            brk_en, brk_pol, auto_oe, off_run, off_idle;
   logic [NCH-1:0]  idle_lvl, ch_pol, oc_pre;
   logic [NCH*MW-1:0] oc_mode;
   logic            wr_reject;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   lockctl_top #(.NCH(NCH), .MODE_W(MW), .ADDR_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_strb(wr_strb), .ch_is_out(ch_is_out),
      .dt_code(dt_code), .lock_lvl(lock_lvl), .brk_en(brk_en),
      .brk_pol(brk_pol), .auto_oe(auto_oe), .off_run(off_run),
      .off_idle(off_idle), .idle_lvl(idle_lvl), .ch_pol(ch_pol),
      .oc_mode(oc_mode), .oc_pre(oc_pre), .wr_reject(wr_reject)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive one write, return the rejection pulse seen one cycle later
   task automatic wr(input logic [1:0] a, input logic [15:0] d,
                     input logic [1:0] s, output logic rej);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
      @(negedge clk);
      wr_en = 1'b0;
      rej = wr_reject;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 dt", {8'h0, dt_code}, 16'h0);
      chk("R1 lvl", {14'h0, lock_lvl}, 16'h0);
      chk("R1 ctl", {11'h0, brk_en, brk_pol, auto_oe, off_run, off_idle}, 16'h0);
      chk("R1 ch", {idle_lvl, ch_pol, oc_pre, 4'h0}, 16'h0);
      chk("R1 mode", {4'h0, oc_mode}, 16'h0);
      chk("R1 rej", {15'h0, wr_reject}, 16'h0);
   endtask

   task automatic t_open();
      logic r;
      do_reset();
      wr(2'd1, 16'h0A05, 2'b11, r);
      chk("R2 R10 idle", {12'h0, idle_lvl}, 16'h5);
      chk("R2 pol", {12'h0, ch_pol}, 16'hA);
      wr(2'd2, 16'hBEEF, 2'b01, r);
      chk("R2 lane mode", {4'h0, oc_mode}, 16'h0037);
      chk("R2 lane pre", {12'h0, oc_pre}, 16'h3);
      wr(2'd0, 16'h7C1C, 2'b10, r);
      chk("R2 dt", {8'h0, dt_code}, 16'h7C);
      chk("R2 brk untouched", {13'h0, brk_en, brk_pol, auto_oe}, 16'h0);
      wr(2'd0, 16'h001C, 2'b01, r);
      chk("R3 lvl zero", {14'h0, lock_lvl}, 16'h0);
      chk("R2 brk", {13'h0, brk_en, brk_pol, auto_oe}, 16'h7);
      chk("R3 no rej", {15'h0, r}, 16'h0);
      wr(2'd0, 16'h0003, 2'b01, r);
      chk("R3 lvl frozen", {14'h0, lock_lvl}, 16'h0);
      chk("R9 rej", {15'h0, r}, 16'h1);
      chk("R9 open part", {13'h0, brk_en, brk_pol, auto_oe}, 16'h0);
      @(negedge clk);
      chk("R9 pulse end", {15'h0, wr_reject}, 16'h0);
   endtask

   task automatic t_level1();
      logic r;
      do_reset();
      wr(2'd0, 16'h5A01, 2'b11, r);
      chk("R8 dt with lock", {8'h0, dt_code}, 16'h5A);
      chk("R8 lvl", {14'h0, lock_lvl}, 16'h1);
      chk("R8 no rej", {15'h0, r}, 16'h0);
      wr(2'd0, 16'h3301, 2'b11, r);
      chk("R4 dt held", {8'h0, dt_code}, 16'h5A);
      chk("R4 rej", {15'h0, r}, 16'h1);
      wr(2'd0, 16'h0025, 2'b01, r);
      chk("R4 brk held", {15'h0, brk_en}, 16'h0);
      chk("R5 off_run open at 1", {15'h0, off_run}, 16'h1);
      chk("R9 rej", {15'h0, r}, 16'h1);
      wr(2'd1, 16'h0F03, 2'b11, r);
      chk("R4 idle held", {12'h0, idle_lvl}, 16'h0);
      chk("R5 pol open at 1", {12'h0, ch_pol}, 16'hF);
   endtask

   task automatic t_level2();
      logic r;
      ch_is_out = 4'b0101;
      do_reset();
      wr(2'd0, 16'h0002, 2'b01, r);
      chk("R3 lvl two", {14'h0, lock_lvl}, 16'h2);
      wr(2'd1, 16'h0F00, 2'b10, r);
      chk("R5 R7 pol", {12'h0, ch_pol}, 16'hA);
      chk("R5 rej", {15'h0, r}, 16'h1);
      wr(2'd0, 16'h0042, 2'b01, r);
      chk("R5 off_idle held", {15'h0, off_idle}, 16'h0);
      wr(2'd2, 16'h5555, 2'b11, r);
      chk("R6 open at 2", {4'h0, oc_mode}, 16'h0B6D);
      chk("R6 rej none", {15'h0, r}, 16'h0);
   endtask

   task automatic t_level3();
      logic r;
      ch_is_out = 4'b0101;
      do_reset();
      wr(2'd0, 16'h0003, 2'b01, r);
      wr(2'd2, 16'hFFFF, 2'b11, r);
      chk("R6 R7 mode", {4'h0, oc_mode}, 16'h0E38);
      chk("R6 R7 pre", {12'h0, oc_pre}, 16'hA);
      chk("R9 rej", {15'h0, r}, 16'h1);
      ch_is_out = 4'b0000;
      wr(2'd2, 16'h1111, 2'b01, r);
      chk("R7 inputs open", {4'h0, oc_mode}, 16'h0E09);
      chk("R7 pre", {12'h0, oc_pre}, 16'h8);
      chk("R7 no rej", {15'h0, r}, 16'h0);
      wr(2'd0, 16'h0003, 2'b01, r);
      chk("R9 same value", {15'h0, r}, 16'h0);
      chk("R3 lvl three", {14'h0, lock_lvl}, 16'h3);
   endtask

   initial begin
      #(200000 * 4);
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      t_reset();
      t_open();
      t_level1();
      t_level2();
      t_level3();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule